// File: doc/BRIEF.md
# Machine Trap-Setup Register Legalizer

This block holds the machine-level trap-setup state of a small RISC-V-style core: the status word, the interrupt-enable and interrupt-pending words, the interrupt and exception delegation masks, and the trap-vector base. Each write arrives as a 12-bit register address, a data word and a write strobe. Before the data is stored, the block cleans it field by field. Bits that are not implemented keep their old value. Privilege encodings that are not supported are dropped. The floating-point context field collapses to two states, and the summary-dirty bit is recomputed.

The supervisor status, enable and pending registers have no storage of their own. They are filtered windows onto the machine registers: a read returns the machine value ANDed with a mask, and a write merges through the same mask and then goes through the machine-level cleaning. Whenever a status write changes a field that affects address translation, the block sends a one-cycle flush pulse to the translation cache. Reads are combinational from the address port.

Top module: `trap_setup_csr`

## Requirements
- R1: A write to the machine status word (address 0x300) updates only SIE[1], MIE[3], SPIE[5], MPIE[7], SPP[8], MPP[12:11], FS[14:13], MPRV[17], SUM[18] and MXR[19]. Every other bit keeps its previous value.
- R2: When a status write carries MPP = 2, or names S (1) or U (0) while that mode is not implemented, MPP keeps its previous value and the other writable fields still update.
- R3: After a status write, a nonzero FS is stored as 3, so FS only ever reads 0 or 3.
- R4: The status bit XLEN-1 (SD) is 1 exactly when FS is 3 or XS[16:15] is 3, and it is recomputed on every status write.
- R5: A status write, through either the machine or the supervisor address, raises the flush output when the stored MXR, MPP, MPRV or SUM value changes. It raises nothing when none of them changes.
- R6: The machine interrupt-enable word (0x304) stores only bits 1, 3, 5, 7 and 9. The machine pending word (0x344) stores only bits 1 and 5. The interrupt-delegation word (0x303) stores only bits 1, 5 and 9. Other bits read 0.
- R7: The exception-delegation word (0x302) stores only cause bits 0 to 9, 12, 13 and 15. Other bits read 0.
- R8: A trap-vector write (0x305) is stored, with bits [1:0] zero, only when its bits [1:0] are 00. Any other value leaves the register unchanged.
- R9: The supervisor enable view (0x104) and pending view (0x144) read as the machine word ANDed with the interrupt-delegation word. A write to either view changes only the machine bits selected by the delegation word, subject to R6.
- R10: The supervisor status view (0x100) reads the status word masked to bits 0, 1, 4, 5, 8, 13–14, 15–16, 18, 19 and XLEN-1. A write to it merges through that mask and then passes through R1 to R4.
- R11: After reset, every register reads 0 except status MPP, which reads 3.
- R12: The flush output is registered. It is high for exactly one cycle, in the cycle after the capturing clock edge of the status write that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 12 | Register address, used for both read and write |
| reg_wdata | input | XLEN | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | XLEN | Combinational read data for reg_addr |
| xlat_flush | output | 1 | One-cycle pulse asking the translation cache to flush |

## Verification
The hardest state to reach from the ports is a supervisor status write that looks active but changes no translation field. In that case the merge must drop both bits outside the supervisor mask and bits the supervisor mask passes but the machine mask rejects, and the flush must stay low. The stimulus first drives the status word into a known state with MPP at 0 and FS at Dirty. It then writes through the supervisor window twice: once to change only MXR, and once with a machine-only enable bit and a user-only bit set. After each write the flush and the machine status read are checked. The delegation-filtered views are reached the same way: a narrow delegation mask is set first, so that a write through the supervisor window can leave visible machine bits untouched.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;
  localparam logic [11:0] A_MSTAT  = 12'h300;
  localparam logic [11:0] A_EDELEG = 12'h302;
  localparam logic [11:0] A_IDELEG = 12'h303;
  localparam logic [11:0] A_MIEN   = 12'h304;
  localparam logic [11:0] A_MVEC   = 12'h305;
  localparam logic [11:0] A_MPEND  = 12'h344;
  localparam logic [11:0] A_SSTAT  = 12'h100;
  localparam logic [11:0] A_SIEN   = 12'h104;
  localparam logic [11:0] A_SPEND  = 12'h144;

  localparam int MPP_LO = 11;
  localparam int FS_LO  = 13;
  localparam int XS_LO  = 15;

  localparam logic [31:0] STAT_WMASK  = 32'h000E_79AA;
  localparam logic [31:0] STAT_XLMASK = 32'h000E_1800;
  localparam logic [31:0] SVIEW_LOW   = 32'h000D_E133;
  localparam logic [31:0] IEN_MASK    = 32'h0000_02AA;
  localparam logic [31:0] PEND_MASK   = 32'h0000_0022;
  localparam logic [31:0] IDLG_MASK   = 32'h0000_0222;
  localparam logic [31:0] EDLG_MASK   = 32'h0000_B3FF;

  typedef struct packed {
    logic mstat;
    logic sstat;
    logic mien;
    logic sien;
    logic mpend;
    logic spend;
    logic ideleg;
    logic edeleg;
    logic mvec;
  } wsel_t;
endpackage

// File: rtl/trap_status_unit.sv
module trap_status_unit
  import trap_csr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter bit HAS_S  = 1'b1,
  parameter bit HAS_U  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_m,
  input  logic            wr_s,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] stat_q,
  output logic            flush_q
);
  localparam int SD_BIT = XLEN - 1;
  localparam logic [XLEN-1:0] WMASK  = XLEN'(STAT_WMASK);
  localparam logic [XLEN-1:0] XLMASK = XLEN'(STAT_XLMASK);
  localparam logic [XLEN-1:0] SMASK  = XLEN'(SVIEW_LOW) | (XLEN'(1) << SD_BIT);
  localparam logic [XLEN-1:0] MPPMSK = XLEN'(3) << MPP_LO;

  logic [XLEN-1:0] src, mask_eff, stat_d;
  logic [1:0]      mpp_req;
  logic            mpp_bad, stat_we, flush_d;

  always_comb begin
    src = wr_s ? ((stat_q & ~SMASK) | (wdata & SMASK)) : wdata;
    mpp_req = src[MPP_LO +: 2];
    mpp_bad = (mpp_req == 2'd2) ||
              (!HAS_S && mpp_req == 2'd1) ||
              (!HAS_U && mpp_req == 2'd0);
    mask_eff = mpp_bad ? (WMASK & ~MPPMSK) : WMASK;
    stat_d = (stat_q & ~mask_eff) | (src & mask_eff);
    if (stat_d[FS_LO +: 2] != 2'b00) stat_d[FS_LO +: 2] = 2'b11;
    stat_d[SD_BIT] = (stat_d[FS_LO +: 2] == 2'b11) || (stat_d[XS_LO +: 2] == 2'b11);
    stat_we = wr_m | wr_s;
    flush_d = stat_we && (((stat_d ^ stat_q) & XLMASK) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= MPPMSK;
    end else if (stat_we) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  assert_fs_two_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[FS_LO +: 2] == 2'b00) || (stat_q[FS_LO +: 2] == 2'b11));
  assert_sd_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[SD_BIT] == ((stat_q[FS_LO +: 2] == 2'b11) || (stat_q[XS_LO +: 2] == 2'b11)));
  assert_mpp_reserved_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_m && wdata[MPP_LO +: 2] == 2'd2) |=> $stable(stat_q[MPP_LO +: 2]));
  assert_flush_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> $past(stat_we));
  assert_no_flush_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && ((stat_d ^ stat_q) & XLMASK) == '0) |=> !flush_q);
endmodule

// File: rtl/trap_irq_unit.sv
module trap_irq_unit
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mien,
  input  logic            wr_sien,
  input  logic            wr_mpend,
  input  logic            wr_spend,
  input  logic            wr_ideleg,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] ien_q,
  output logic [XLEN-1:0] pend_q,
  output logic [XLEN-1:0] ideleg_q
);
  localparam logic [XLEN-1:0] IENM = XLEN'(IEN_MASK);
  localparam logic [XLEN-1:0] PNDM = XLEN'(PEND_MASK);
  localparam logic [XLEN-1:0] DLGM = XLEN'(IDLG_MASK);

  logic [XLEN-1:0] ien_src, pend_src, ien_d, pend_d, ideleg_d;
  logic            ien_we, pend_we;

  always_comb begin
    ien_src  = wr_sien  ? ((ien_q  & ~ideleg_q) | (wdata & ideleg_q)) : wdata;
    pend_src = wr_spend ? ((pend_q & ~ideleg_q) | (wdata & ideleg_q)) : wdata;
    ien_d    = (ien_q  & ~IENM) | (ien_src  & IENM);
    pend_d   = (pend_q & ~PNDM) | (pend_src & PNDM);
    ideleg_d = (ideleg_q & ~DLGM) | (wdata & DLGM);
    ien_we   = wr_mien  | wr_sien;
    pend_we  = wr_mpend | wr_spend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (ien_we) begin
      ien_q <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_we) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ideleg_q <= '0;
    end else if (wr_ideleg) begin
      ideleg_q <= ideleg_d;
    end
  end

  assert_sien_scope_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sien |=> ((ien_q & ~ideleg_q) == $past(ien_q & ~ideleg_q)));
  assert_spend_scope_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_spend |=> ((pend_q & ~ideleg_q) == $past(pend_q & ~ideleg_q)));
  assert_ideleg_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ideleg |=> $stable(ideleg_q));
endmodule

// File: rtl/trap_vec_unit.sv
module trap_vec_unit
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_edeleg,
  input  logic            wr_mvec,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] edeleg_q,
  output logic [XLEN-1:0] mvec_q
);
  localparam logic [XLEN-1:0] EDM = XLEN'(EDLG_MASK);

  logic [XLEN-1:0] edeleg_d, mvec_d;
  logic            mvec_we;

  always_comb begin
    edeleg_d = wdata & EDM;
    mvec_d   = {wdata[XLEN-1:2], 2'b00};
    mvec_we  = wr_mvec && (wdata[1:0] == 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edeleg_q <= '0;
    end else if (wr_edeleg) begin
      edeleg_q <= edeleg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mvec_q <= '0;
    end else if (mvec_we) begin
      mvec_q <= mvec_d;
    end
  end

  assert_vec_mode_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mvec && wdata[1:0] != 2'b00) |=> $stable(mvec_q));
  assert_vec_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mvec_q[1:0] == 2'b00);
  assert_edeleg_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edeleg_q & ~EDM) == '0);
endmodule

// File: rtl/trap_setup_csr.sv
module trap_setup_csr
  import trap_csr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     reg_addr,
  input  logic [XLEN-1:0] reg_wdata,
  input  logic            reg_we,
  output logic [XLEN-1:0] reg_rdata,
  output logic            xlat_flush
);
  localparam logic [XLEN-1:0] SVIEW = XLEN'(SVIEW_LOW) | (XLEN'(1) << (XLEN - 1));

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  wsel_t           ws;
  logic [XLEN-1:0] stat_q, ien_q, pend_q, ideleg_q, edeleg_q, mvec_q;

  always_comb begin
    ws        = '0;
    ws.mstat  = reg_we && reg_addr == A_MSTAT;
    ws.sstat  = reg_we && reg_addr == A_SSTAT;
    ws.mien   = reg_we && reg_addr == A_MIEN;
    ws.sien   = reg_we && reg_addr == A_SIEN;
    ws.mpend  = reg_we && reg_addr == A_MPEND;
    ws.spend  = reg_we && reg_addr == A_SPEND;
    ws.ideleg = reg_we && reg_addr == A_IDELEG;
    ws.edeleg = reg_we && reg_addr == A_EDELEG;
    ws.mvec   = reg_we && reg_addr == A_MVEC;
  end

  trap_status_unit #(.XLEN(XLEN), .HAS_S(HAS_S), .HAS_U(HAS_U)) u_stat (
    .clk(clk), .rst_n(rst_sn), .wr_m(ws.mstat), .wr_s(ws.sstat),
    .wdata(reg_wdata), .stat_q(stat_q), .flush_q(xlat_flush));

  trap_irq_unit #(.XLEN(XLEN)) u_irq (
    .clk(clk), .rst_n(rst_sn), .wr_mien(ws.mien), .wr_sien(ws.sien),
    .wr_mpend(ws.mpend), .wr_spend(ws.spend), .wr_ideleg(ws.ideleg),
    .wdata(reg_wdata), .ien_q(ien_q), .pend_q(pend_q), .ideleg_q(ideleg_q));

  trap_vec_unit #(.XLEN(XLEN)) u_vec (
    .clk(clk), .rst_n(rst_sn), .wr_edeleg(ws.edeleg), .wr_mvec(ws.mvec),
    .wdata(reg_wdata), .edeleg_q(edeleg_q), .mvec_q(mvec_q));

  always_comb begin
    unique case (reg_addr)
      A_MSTAT:  reg_rdata = stat_q;
      A_SSTAT:  reg_rdata = stat_q & SVIEW;
      A_MIEN:   reg_rdata = ien_q;
      A_SIEN:   reg_rdata = ien_q & ideleg_q;
      A_MPEND:  reg_rdata = pend_q;
      A_SPEND:  reg_rdata = pend_q & ideleg_q;
      A_IDELEG: reg_rdata = ideleg_q;
      A_EDELEG: reg_rdata = edeleg_q;
      A_MVEC:   reg_rdata = mvec_q;
      default:  reg_rdata = '0;
    endcase
  end

  assert_sview_subset_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_addr == A_SSTAT) |-> ((reg_rdata & ~SVIEW) == '0));
  assert_flush_single_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    (xlat_flush && !(ws.mstat || ws.sstat)) |=> !xlat_flush);
endmodule

// File: tb/trap_setup_csr_test.sv
module trap_setup_csr_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        xlat_flush;

  always #(PERIOD/2) clk = ~clk;

  trap_setup_csr uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .xlat_flush(xlat_flush));

  typedef struct {
    bit          is_flush;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  logic  chk_vld = 1'b0;
  bit    done = 1'b0;

  always @(negedge clk) begin
    if (chk_vld && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_flush ? {31'b0, xlat_flush} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input bit exp_flush, input string tag);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
    sb.push_back('{1'b1, {31'b0, exp_flush}, tag});
    chk_vld = 1'b1;
    @(posedge clk); #1;
    chk_vld = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    sb.push_back('{1'b0, e, tag});
    chk_vld = 1'b1;
    @(posedge clk); #1;
    chk_vld = 1'b0;
  endtask

  task automatic idle_flush(input string tag);
    sb.push_back('{1'b1, 32'h0, tag});
    chk_vld = 1'b1;
    @(posedge clk); #1;
    chk_vld = 1'b0;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R11 reset values
    rd(12'h300, 32'h0000_1800, "R11 status reset");
    rd(12'h305, 32'h0, "R11 vector reset");
    rd(12'h304, 32'h0, "R11 enable reset");
    idle_flush("R11 flush reset");
    // R1 R3 R4 R5 full write
    wr(12'h300, 32'hFFFF_FFFF, 1'b1, "R5 flush on MXR change");
    rd(12'h300, 32'h800E_79AA, "R1 writable fields");
    idle_flush("R12 flush one cycle");
    // R2 reserved MPP kept
    wr(12'h300, 32'h0000_1000, 1'b1, "R5 flush on SUM/MPRV/MXR clear");
    rd(12'h300, 32'h0000_1800, "R2 MPP reserved kept");
    // R3 FS forced dirty, MPP to U
    wr(12'h300, 32'h0000_2000, 1'b1, "R5 flush on MPP change");
    rd(12'h300, 32'h8000_6000, "R3 FS to dirty R4 SD");
    wr(12'h300, 32'h0000_2002, 1'b0, "R5 no flush");
    rd(12'h300, 32'h8000_6002, "R4 SD status");
    // R6 R7
    wr(12'h304, 32'hFFFF_FFFF, 1'b0, "R6 enable no flush");
    rd(12'h304, 32'h0000_02AA, "R6 enable mask");
    wr(12'h303, 32'hFFFF_FFFF, 1'b0, "R6 deleg no flush");
    rd(12'h303, 32'h0000_0222, "R6 deleg mask");
    rd(12'h104, 32'h0000_0222, "R9 sie view");
    wr(12'h302, 32'hFFFF_FFFF, 1'b0, "R7 no flush");
    rd(12'h302, 32'h0000_B3FF, "R7 exception deleg mask");
    // R8
    wr(12'h305, 32'h8000_0100, 1'b0, "R8 no flush");
    rd(12'h305, 32'h8000_0100, "R8 direct stored");
    wr(12'h305, 32'h1234_5601, 1'b0, "R8 no flush");
    rd(12'h305, 32'h8000_0100, "R8 vectored rejected");
    wr(12'h305, 32'h1234_5603, 1'b0, "R8 no flush");
    rd(12'h305, 32'h8000_0100, "R8 reserved rejected");
    // R9 filtered views
    wr(12'h303, 32'h0000_0020, 1'b0, "R9 no flush");
    wr(12'h304, 32'h0, 1'b0, "R9 no flush");
    wr(12'h104, 32'hFFFF_FFFF, 1'b0, "R9 no flush");
    rd(12'h304, 32'h0000_0020, "R9 sie write scope");
    rd(12'h104, 32'h0000_0020, "R9 sie read");
    wr(12'h344, 32'hFFFF_FFFF, 1'b0, "R6 no flush");
    rd(12'h344, 32'h0000_0022, "R6 pending mask");
    rd(12'h144, 32'h0000_0020, "R9 sip read");
    wr(12'h144, 32'h0, 1'b0, "R9 no flush");
    rd(12'h344, 32'h0000_0002, "R9 sip write scope");
    // R10 supervisor status view
    rd(12'h100, 32'h8000_6002, "R10 sstatus read");
    wr(12'h100, 32'h0008_0000, 1'b1, "R10 R5 flush via sstatus");
    rd(12'h300, 32'h0008_0000, "R10 sstatus merge");
    wr(12'h100, 32'h0008_0018, 1'b0, "R10 R5 no flush");
    rd(12'h300, 32'h0008_0000, "R10 foreign bits dropped");
    rd(12'h100, 32'h0008_0000, "R10 sstatus read back");
    idle_flush("R12 flush idle");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule